// File: doc/BRIEF.md
# Console Serial Port Register Interface

This block is an asynchronous serial console port that a processor sees as a window of eight consecutive 16-bit I/O words. It has one receive channel and one transmit channel. Each channel has a data word, a status word and a control word. A single format setting, held in the receive control word, selects the character length, the stop-bit count and even parity for both directions. The receiver reports framing, parity and overrun conditions as sticky flags. The port raises one interrupt request for receive and one for transmit, each gated by its own enable bit.

The processor side is a plain register port: a 3-bit word offset, a write strobe, a read strobe, 16-bit write data and combinational read data. A read side effect takes place on the clock edge at which the read strobe is high. The serial side has a receive line, a transmit line and an input tick that pulses once per sixteenth of a bit time. The receiver oversamples on that tick, and the transmitter times its bits with it.

Top module: `sercon_port`

## Requirements
- R1: Offset 0 reads the most recently received character, zero-extended to 16 bits. Offsets 1 and 4 always read 0x0000.
- R2: The receive status word at offset 2 has bit 0 = receive interrupt enable, bit 3 = data available, bit 4 = OR of the three error flags, bit 5 = framing error, bit 6 = parity error and bit 7 = overrun. All other bits read zero.
- R3: The receive control word at offset 3 sets the character length from bits 11 and 12, written as (bit 11, bit 12): (1,1) gives 5 bits, (0,1) gives 6, (1,0) gives 7 and (0,0) gives 8. The same length is used for receive and transmit.
- R4: Bit 13 of the control word set to 1 gives one stop bit. Bit 13 set to 0 gives two stop bits, or one and a half stop bits when the length is 5. The transmitter holds the stop level for 16, 32 or 24 ticks respectively.
- R5: Bit 14 of the control word set to 1 adds an even parity bit after the data bits. The transmitter generates it, and the receiver checks it and sets the parity error flag on a mismatch.
- R6: A write to offset 5 while the transmitter is ready sends the frame on the transmit line. The frame is a low start bit, then the data bits LSB first, then parity if enabled, then the stop level high. Each bit lasts 16 ticks. The line is high when idle. A write to offset 5 while the transmitter is busy is ignored.
- R7: The transmit status word at offset 6 has bit 0 = transmit interrupt enable and bit 3 = ready. Ready is low from an accepted write until the stop time has elapsed. Offset 7 bit 0 sets the transmit interrupt enable.
- R8: The receiver confirms a start bit half a bit time after the falling edge. A low pulse shorter than that does not start a character.
- R9: A character whose first stop bit is sampled low sets the framing error flag.
- R10: A character that completes while data available is still set sets the overrun flag and replaces the held character.
- R11: A read of offset 0 clears data available and all three error flags.
- R12: The receive interrupt output is high exactly when the receive enable and data available are both set. The transmit interrupt output is high exactly when the transmit enable and ready are both set.
- R13: After reset the transmit line is high, the transmitter is ready, no data is available, no error flag is set, both enables are 0 and the format is 8 data bits, two stop bits, no parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word offset within the register window |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; applies read side effects |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| tick16 | input | 1 | One pulse per sixteenth of a bit time |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |

## Verification
The hardest state to reach is a character that ends in the same state as earlier trouble: a second character landing on an unread one, or a stop bit held low that must not re-trigger the start detector. The bench reaches these by driving the receive line bit by bit from its own frame builder. Its only inputs are a chosen level per bit, a parity flip and a stop level. It sends two frames back to back without a read in between, and it sends one frame with a stop bit held low followed by a return high. A quarter-bit low pulse checks that start confirmation rejects glitches. Randomly chosen formats and characters then cover every length, stop and parity combination in both directions.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CHAR_MAX = 8;

  // len_sel = {ctl bit 12, ctl bit 11}
  typedef struct packed {
    logic       par_en;
    logic       one_stop;
    logic [1:0] len_sel;
  } fmt_t;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_START,
    LS_DATA,
    LS_PAR,
    LS_STOP
  } line_st_e;

  function automatic logic [3:0] char_len(input logic [1:0] len_sel);
    return 4'd8 - {2'b00, len_sel};
  endfunction

  function automatic logic even_par(input logic [CHAR_MAX-1:0] d, input logic [3:0] len);
    logic p;
    p = 1'b0;
    for (int i = 0; i < CHAR_MAX; i++)
      if (4'(i) < len) p = p ^ d[i];
    return p;
  endfunction

  function automatic int unsigned stop_len(input fmt_t f, input int unsigned os);
    if (f.one_stop) return os;
    else if (char_len(f.len_sel) == 4'd5) return os + os / 2;
    else return 2 * os;
  endfunction

endpackage

// File: rtl/sercon_tx.sv
module sercon_tx
  import sercon_pkg::*;
#(
  parameter int unsigned OS_RATE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  fmt_t                fmt_i,
  input  logic                load_i,
  input  logic [CHAR_MAX-1:0] data_i,
  output logic                ready_o,
  output logic                accept_o,
  output logic                txd_o
);

  localparam int unsigned CW = $clog2(2 * OS_RATE);

  line_st_e            st;
  logic [CW-1:0]       cnt;
  logic [3:0]          idx;
  logic [CHAR_MAX-1:0] sh;
  fmt_t                fmt_q;
  logic [3:0]          len;
  logic                bit_end;

  assign len      = char_len(fmt_q.len_sel);
  assign ready_o  = (st == LS_IDLE);
  assign accept_o = load_i && ready_o;
  assign bit_end  = (st == LS_STOP) ? (cnt == CW'(stop_len(fmt_q, OS_RATE) - 1))
                                    : (cnt == CW'(OS_RATE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LS_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sh    <= '0;
      fmt_q <= '0;
      txd_o <= 1'b1;
    end else if (accept_o) begin
      st    <= LS_START;
      cnt   <= '0;
      idx   <= '0;
      sh    <= data_i;
      fmt_q <= fmt_i;
      txd_o <= 1'b0;
    end else if (tick && st != LS_IDLE) begin
      if (!bit_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          LS_START: begin
            st    <= LS_DATA;
            txd_o <= sh[0];
            idx   <= 4'd1;
          end
          LS_DATA: begin
            if (idx == len) begin
              if (fmt_q.par_en) begin
                st    <= LS_PAR;
                txd_o <= even_par(sh, len);
              end else begin
                st    <= LS_STOP;
                txd_o <= 1'b1;
              end
            end else begin
              txd_o <= sh[idx[2:0]];
              idx   <= idx + 1'b1;
            end
          end
          LS_PAR: begin
            st    <= LS_STOP;
            txd_o <= 1'b1;
          end
          default: begin
            st    <= LS_IDLE;
            txd_o <= 1'b1;
          end
        endcase
      end
    end
  end

  // R6: idle line stays high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_IDLE) |-> txd_o);

  // R6: accepted write drives the start bit at once and drops ready
  a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (!txd_o && !ready_o));

  // R6: a write while busy leaves the held character unchanged
  a_r6_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !ready_o) |=> $stable(sh));

  // R4: stop time keeps the line high
  a_r4_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LS_STOP) |-> txd_o);

endmodule

// File: rtl/sercon_rx.sv
module sercon_rx
  import sercon_pkg::*;
#(
  parameter int unsigned OS_RATE     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  fmt_t                fmt_i,
  input  logic                rxd_i,
  output logic                done_o,
  output logic [CHAR_MAX-1:0] data_o,
  output logic                frm_err_o,
  output logic                par_err_o
);

  localparam int unsigned CW  = $clog2(OS_RATE);
  localparam int unsigned MID = OS_RATE / 2 - 1;

  logic [SYNC_STAGES-1:0] sy;
  logic                   rx_s;
  logic                   prev;
  line_st_e               st;
  logic [CW-1:0]          cnt;
  logic [3:0]             idx;
  logic [CHAR_MAX-1:0]    acc;
  fmt_t                   fmt_q;
  logic                   perr;
  logic [3:0]             len;
  logic                   start_seen;

  assign rx_s       = sy[SYNC_STAGES-1];
  assign len        = char_len(fmt_q.len_sel);
  assign start_seen = tick && (st == LS_IDLE) && prev && !rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy        <= '1;
      prev      <= 1'b1;
      st        <= LS_IDLE;
      cnt       <= '0;
      idx       <= '0;
      acc       <= '0;
      fmt_q     <= '0;
      perr      <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      frm_err_o <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      sy     <= {sy[SYNC_STAGES-2:0], rxd_i};
      done_o <= 1'b0;
      if (tick) begin
        prev <= rx_s;
        case (st)
          LS_IDLE: begin
            if (start_seen) begin
              st    <= LS_START;
              cnt   <= '0;
              idx   <= '0;
              acc   <= '0;
              perr  <= 1'b0;
              fmt_q <= fmt_i;
            end
          end
          LS_START: begin
            if (cnt == CW'(MID)) begin
              cnt <= '0;
              st  <= rx_s ? LS_IDLE : LS_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LS_DATA: begin
            if (cnt == CW'(OS_RATE - 1)) begin
              cnt              <= '0;
              acc[idx[2:0]]    <= rx_s;
              idx              <= idx + 1'b1;
              if (idx == len - 1'b1) st <= fmt_q.par_en ? LS_PAR : LS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LS_PAR: begin
            if (cnt == CW'(OS_RATE - 1)) begin
              cnt  <= '0;
              perr <= rx_s ^ even_par(acc, len);
              st   <= LS_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          LS_STOP: begin
            if (cnt == CW'(OS_RATE - 1)) begin
              cnt       <= '0;
              st        <= LS_IDLE;
              done_o    <= 1'b1;
              data_o    <= acc;
              frm_err_o <= !rx_s;
              par_err_o <= perr;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= LS_IDLE;
        endcase
      end
    end
  end

  // R8: a line found high at the start midpoint abandons the character
  a_r8_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && st == LS_START && cnt == CW'(MID) && rx_s) |=> (st == LS_IDLE));

  // R9: a completion is a single-cycle event separated from the next
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/sercon_port.sv
module sercon_port
  import sercon_pkg::*;
#(
  parameter int unsigned OS_RATE     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              tick16,
  input  logic              rxd,
  output logic              txd,
  output logic              irq_rx,
  output logic              irq_tx
);

  localparam logic [2:0] OFS_RDATA = 3'd0;
  localparam logic [2:0] OFS_RSTAT = 3'd2;
  localparam logic [2:0] OFS_RCTL  = 3'd3;
  localparam logic [2:0] OFS_WDATA = 3'd5;
  localparam logic [2:0] OFS_WSTAT = 3'd6;
  localparam logic [2:0] OFS_WCTL  = 3'd7;

  fmt_t                fmt;
  logic                rx_ie, tx_ie;
  logic [CHAR_MAX-1:0] rx_hold;
  logic                rx_avail, st_frm, st_par, st_ovr, err_any;
  logic                rx_done, rx_frm, rx_perr;
  logic [CHAR_MAX-1:0] rx_char;
  logic                tx_ready, tx_accept, tx_load;
  logic                data_read;

  assign data_read = reg_rd && (reg_addr == OFS_RDATA);
  assign tx_load   = reg_wr && (reg_addr == OFS_WDATA);
  assign err_any   = st_frm | st_par | st_ovr;

  sercon_rx #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .fmt_i     (fmt),
    .rxd_i     (rxd),
    .done_o    (rx_done),
    .data_o    (rx_char),
    .frm_err_o (rx_frm),
    .par_err_o (rx_perr)
  );

  sercon_tx #(.OS_RATE(OS_RATE)) i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .fmt_i    (fmt),
    .load_i   (tx_load),
    .data_i   (reg_wdata[CHAR_MAX-1:0]),
    .ready_o  (tx_ready),
    .accept_o (tx_accept),
    .txd_o    (txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt   <= '0;
      rx_ie <= 1'b0;
      tx_ie <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_RCTL) begin
        rx_ie <= reg_wdata[0];
        fmt   <= '{par_en: reg_wdata[14], one_stop: reg_wdata[13],
                   len_sel: {reg_wdata[12], reg_wdata[11]}};
      end
      if (reg_addr == OFS_WCTL) tx_ie <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold  <= '0;
      rx_avail <= 1'b0;
      st_frm   <= 1'b0;
      st_par   <= 1'b0;
      st_ovr   <= 1'b0;
    end else begin
      if (rx_done) rx_hold <= rx_char;
      rx_avail <= rx_done | (rx_avail & ~data_read);
      st_frm   <= (st_frm & ~data_read) | (rx_done & rx_frm);
      st_par   <= (st_par & ~data_read) | (rx_done & rx_perr);
      st_ovr   <= (st_ovr & ~data_read) | (rx_done & rx_avail & ~data_read);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_RDATA: reg_rdata[CHAR_MAX-1:0] = rx_hold;
      OFS_RSTAT: begin
        reg_rdata[0] = rx_ie;
        reg_rdata[3] = rx_avail;
        reg_rdata[4] = err_any;
        reg_rdata[5] = st_frm;
        reg_rdata[6] = st_par;
        reg_rdata[7] = st_ovr;
      end
      OFS_RCTL: begin
        reg_rdata[0]  = rx_ie;
        reg_rdata[11] = fmt.len_sel[0];
        reg_rdata[12] = fmt.len_sel[1];
        reg_rdata[13] = fmt.one_stop;
        reg_rdata[14] = fmt.par_en;
      end
      OFS_WSTAT: begin
        reg_rdata[0] = tx_ie;
        reg_rdata[3] = tx_ready;
      end
      OFS_WCTL: reg_rdata[0] = tx_ie;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_rx = rx_ie & rx_avail;
  assign irq_tx = tx_ie & tx_ready;

  // R10: a completion on top of unread data records an overrun
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_avail && !data_read) |=> st_ovr);

  // R11: a data read with no new completion leaves nothing pending
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !rx_done) |=> (!rx_avail && !err_any));

  // R1: a completion makes its character visible at offset 0
  a_r1_hold_updates: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rx_avail && rx_hold == $past(rx_char)));

  // R7: an accepted write leaves the transmitter busy on the next cycle
  a_r7_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !tx_ready);

endmodule

// File: tb/test_sercon_port.sv
`timescale 1ns/1ps
module test_sercon_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tick16 = 1'b0;
  logic        rxd = 1'b1;
  logic        txd, irq_rx, irq_tx;

  int unsigned nchk = 0, nfail = 0;
  int unsigned cyc = 0;
  logic [1:0]  tcnt = '0;
  localparam int BIT_CLK = 64;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    tcnt   <= tcnt + 1'b1;
    tick16 <= (tcnt == 2'd3);
  end

  sercon_port i_sercon_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick16(tick16), .rxd(rxd),
    .txd(txd), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // R3 length code, bench's own table
  function automatic int blen(input logic b11, input logic b12);
    case ({b11, b12})
      2'b11: return 5;
      2'b01: return 6;
      2'b10: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic bpar(input logic [7:0] d, input int len);
    logic p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    return p;
  endfunction

  function automatic int stop_ticks(input logic one, input int len);
    if (one) return 16;
    return (len == 5) ? 24 : 32;
  endfunction

  function automatic logic [15:0] mk_ctl(input logic ie, input logic b11, input logic b12,
                                          input logic one, input logic par);
    return {1'b0, par, one, b12, b11, 10'b0, ie};
  endfunction

  task automatic hold_line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input int len, input logic par_en,
                           input logic bad_par, input logic stop_lvl, input int stop_clk);
    hold_line(1'b0, BIT_CLK);
    for (int i = 0; i < len; i++) hold_line(d[i], BIT_CLK);
    if (par_en) hold_line(bpar(d, len) ^ bad_par, BIT_CLK);
    hold_line(stop_lvl, BIT_CLK);
    hold_line(1'b1, stop_clk + BIT_CLK);
  endtask

  task automatic wait_cyc(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  // Transmit one character and decode it from the line at bit midpoints
  task automatic tx_run(input logic [7:0] d, input int len, input logic par_en,
                        input logic one, input logic busy_wr, input string tag);
    int unsigned k, tend;
    logic [7:0] got;
    logic [15:0] s;
    int total;
    got = '0;
    wr(3'd5, {8'h00, d});
    k = cyc;
    if (busy_wr) begin
      wr(3'd5, {8'h00, ~d});
      rd(3'd6, s);
      chk({tag, " R7 busy status"}, s & 16'h0008, 16'h0000);
    end
    wait_cyc(k + 32);
    chk({tag, " R6 start bit"}, txd, 0);
    for (int i = 0; i < len; i++) begin
      wait_cyc(k + 32 + BIT_CLK * (i + 1));
      got[i] = txd;
    end
    chk({tag, " R6 R3 data"}, got, d & 8'((1 << len) - 1));
    if (par_en) begin
      wait_cyc(k + 32 + BIT_CLK * (len + 1));
      chk({tag, " R5 parity bit"}, txd, bpar(d, len));
    end
    wait_cyc(k + 32 + BIT_CLK * (len + 1 + int'(par_en)));
    chk({tag, " R6 stop level"}, txd, 1);
    s = 16'h0;
    while (s[3] == 1'b0) rd(3'd6, s);
    tend = cyc;
    total = 4 * ((1 + len + int'(par_en)) * 16 + stop_ticks(one, len));
    chk({tag, " R4 frame time"}, (int'(tend - k) >= total - 6) && (int'(tend - k) <= total + 6), 1);
  endtask

  task automatic rx_run(input logic [7:0] d, input logic b11, input logic b12, input logic one,
                        input logic par, input logic bad_par, input string tag);
    int len;
    logic [15:0] s;
    len = blen(b11, b12);
    wr(3'd3, mk_ctl(1'b0, b11, b12, one, par));
    send_char(d, len, par, bad_par, 1'b1, stop_ticks(one, len) * 4);
    rd(3'd2, s);
    chk({tag, " R2 R5 status"}, s, bad_par ? 16'h0058 : 16'h0008);
    rd(3'd0, s);
    chk({tag, " R1 R3 data"}, s, {8'h00, d & 8'((1 << len) - 1)});
    rd(3'd2, s);
    chk({tag, " R11 status after read"}, s, 16'h0000);
  endtask

  initial begin
    logic [15:0] s;
    void'($urandom(32'h0C0FFEE5));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state
    chk("R13 txd idle", txd, 1);
    chk("R13 irq", {irq_rx, irq_tx}, 0);
    rd(3'd2, s); chk("R13 R2 rx status", s, 16'h0000);
    rd(3'd6, s); chk("R13 R7 tx status", s, 16'h0008);
    rd(3'd3, s); chk("R13 control", s, 16'h0000);
    rd(3'd1, s); chk("R1 offset 1 zero", s, 16'h0000);
    rd(3'd4, s); chk("R1 offset 4 zero", s, 16'h0000);

    // Directed receive formats
    rx_run(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "rx 8N2");
    rx_run(8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "rx 5E1.5");
    rx_run(8'h6B, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "rx 7E1 badpar");

    // R9 framing error, stop held low
    wr(3'd3, mk_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    send_char(8'h3C, 8, 1'b0, 1'b0, 1'b0, BIT_CLK);
    rd(3'd2, s); chk("R9 framing status", s, 16'h0038);
    rd(3'd0, s); chk("R9 data", s, 16'h003C);
    rd(3'd2, s); chk("R11 errors cleared", s, 16'h0000);

    // R10 overrun
    send_char(8'h11, 8, 1'b0, 1'b0, 1'b1, BIT_CLK);
    send_char(8'h22, 8, 1'b0, 1'b0, 1'b1, BIT_CLK);
    rd(3'd2, s); chk("R10 overrun status", s, 16'h0098);
    rd(3'd0, s); chk("R10 newest kept", s, 16'h0022);
    rd(3'd2, s); chk("R11 overrun cleared", s, 16'h0000);

    // R8 short low pulse
    hold_line(1'b0, 16);
    hold_line(1'b1, 12 * BIT_CLK);
    rd(3'd2, s); chk("R8 glitch ignored", s, 16'h0000);

    // R12 receive interrupt
    wr(3'd3, mk_ctl(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R12 irq_rx idle", irq_rx, 0);
    send_char(8'h5A, 8, 1'b0, 1'b0, 1'b1, BIT_CLK);
    chk("R12 irq_rx raised", irq_rx, 1);
    rd(3'd2, s); chk("R2 enable bit", s, 16'h0009);
    rd(3'd0, s);
    chk("R12 irq_rx dropped", irq_rx, 0);

    // R12 R7 transmit interrupt
    chk("R12 irq_tx off", irq_tx, 0);
    wr(3'd7, 16'h0001);
    chk("R12 irq_tx on", irq_tx, 1);
    rd(3'd6, s); chk("R7 tx status enabled", s, 16'h0009);
    rd(3'd7, s); chk("R7 tx control readback", s, 16'h0001);
    wr(3'd3, mk_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(3'd5, 16'h0081);
    chk("R12 irq_tx busy", irq_tx, 0);
    s = 16'h0;
    while (s[3] == 1'b0) rd(3'd6, s);
    chk("R12 irq_tx back", irq_tx, 1);
    wr(3'd7, 16'h0000);

    // Directed transmit formats
    wr(3'd3, mk_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    tx_run(8'h3C, 8, 1'b0, 1'b1, 1'b1, "tx 8N1 busywr");
    wr(3'd3, mk_ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b1));
    tx_run(8'h17, 5, 1'b1, 1'b0, 1'b0, "tx 5E1.5");
    wr(3'd3, mk_ctl(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    tx_run(8'hC9, 7, 1'b0, 1'b0, 1'b0, "tx 7N2");

    // Random formats, both directions
    for (int n = 0; n < 12; n++) begin
      logic b11, b12, one, par, bad;
      logic [7:0] d;
      b11 = 1'($urandom); b12 = 1'($urandom); one = 1'($urandom);
      par = 1'($urandom); bad = par & 1'($urandom); d = 8'($urandom);
      rx_run(d, b11, b12, one, par, bad, "rand rx");
      d = 8'($urandom);
      wr(3'd3, mk_ctl(1'b0, b11, b12, one, par));
      tx_run(d, blen(b11, b12), par, one, 1'($urandom), "rand tx");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule